// File: doc/BRIEF.md
# Two-Wire Converter Readout Slave

This block is the serial-bus face of a 16-bit sampling converter. It watches the open-drain clock and data lines of a two-wire bus, recognises bus conditions, takes in the address byte, and on a read addressed to it starts a conversion. It holds the clock line low until the converter returns its result, then shifts the result back to the master one byte at a time. The analog core is not part of the block. It is reached through a one-cycle start pulse and a valid/ready result port.

Both bus lines are sampled in a fast system clock domain, synchronised, and passed through a stability filter before any edge is decoded. The block drives each line only low, through a pull-low output, and a released line reads as high. A master code byte switches the interface into high-speed timing. That mode survives repeated START conditions and is left only on STOP.

Back-pressure on the result port works as follows. `conv_ready` is high only while the block is stretching the clock and waiting for a result. A word moves only in a cycle where `conv_valid` and `conv_ready` are both high. The converter must hold `conv_valid` and `conv_data` steady until that cycle.

Top module: `adc_i2c_slave`

## Requirements
- R1: After reset, and whenever the bus is idle, neither line is pulled low, `hs_mode` is 0 and `conv_start` is 0.
- R2: A START (SDA falls while SCL is high) seen at any point abandons the current byte and begins a fresh address byte. A STOP (SDA rises while SCL is high) returns the block to idle.
- R3: The first byte after a START, sent MSB first, is acknowledged by pulling SDA low in its ninth clock only when it equals {DEV_ADDR, 1} (read bit 1). With DEV_ADDR = 7'h35 that byte is 8'h6B. Any other byte gets no acknowledge, and the block drives nothing until the next START or STOP.
- R4: A matching address produces exactly one `conv_start` pulse, one clock cycle wide.
- R5: From the SCL fall that ends the address acknowledge, SCL is held low until a result is accepted (`conv_valid` and `conv_ready` both high). It is released in the following cycle. `conv_ready` is high only during this wait.
- R6: The accepted 16-bit result is sent high byte first, each byte MSB first. The block changes its SDA drive only while the filtered SCL is low.
- R7: A master ACK (SDA low in the ninth clock) after a data byte continues with the next byte, and after the low byte it returns to the high byte. A NACK releases SDA for the rest of the transfer.
- R8: A first byte of the form 8'b00001xxx sets `hs_mode` and is not acknowledged. `hs_mode` is kept across a repeated START and cleared by STOP.
- R9: A pulse on either line shorter than FILT_LEN system clocks has no effect on the decoded bus traffic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Sensed level of the bus clock line |
| sda_in | input | 1 | Sensed level of the bus data line |
| scl_pull_low | output | 1 | 1 pulls the clock line low (stretching) |
| sda_pull_low | output | 1 | 1 pulls the data line low |
| conv_start | output | 1 | One-cycle request to begin a conversion |
| conv_valid | input | 1 | Converter result is present |
| conv_ready | output | 1 | Block waits for and accepts a result |
| conv_data | input | 16 | Converter result word |
| hs_mode | output | 1 | High-speed timing mode is active |

## Verification
The bench builds the block with DEV_ADDR = 7'h35, RES_W = 16 and FILT_LEN = 4. A master half-period of 40 system clocks leaves the filter delay well inside each phase. At that setting a two-cycle SDA spike during SCL high is short enough to be rejected, yet long enough that an unfiltered decoder would see a false START or STOP. The converter model's latency is set per test. A 1000-cycle latency makes the clock stretch measurable in the master's first data clock. A 2-cycle latency checks that no stretch is seen when the result is already waiting.

// File: rtl/adc_i2c_pkg.sv
package adc_i2c_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_WAIT,
    ST_SEND,
    ST_RACK,
    ST_SKIP
  } rd_state_e;

  localparam logic [4:0] HS_CODE_PREFIX = 5'b00001;
endpackage

// File: rtl/adc_i2c_line_filter.sv
module adc_i2c_line_filter #(
  parameter int LINES    = 2,
  parameter int FILT_LEN = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] raw_i,
  output logic [LINES-1:0] clean_o
);
  localparam int CW = $clog2(FILT_LEN + 1);

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [1:0]    sync_q;
    logic [CW-1:0] cnt_q;
    logic          level_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sync_q  <= 2'b11;
        cnt_q   <= '0;
        level_q <= 1'b1;
      end else begin
        sync_q <= {sync_q[0], raw_i[g]};
        if (sync_q[1] == level_q) begin
          cnt_q <= '0;
        end else if (cnt_q == CW'(FILT_LEN - 1)) begin
          level_q <= sync_q[1];
          cnt_q   <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end

    assign clean_o[g] = level_q;
  end
endmodule

// File: rtl/adc_i2c_bus_events.sv
module adc_i2c_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_f,
  input  logic sda_f,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  assign scl_rise  = !scl_q && scl_f;
  assign scl_fall  = scl_q && !scl_f;
  assign start_det = scl_q && scl_f && sda_q && !sda_f;
  assign stop_det  = scl_q && scl_f && !sda_q && sda_f;
endmodule

// File: rtl/adc_i2c_slave.sv
module adc_i2c_slave #(
  parameter logic [6:0] DEV_ADDR = 7'h35,
  parameter int         RES_W    = 16,
  parameter int         FILT_LEN = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_in,
  input  logic             sda_in,
  output logic             scl_pull_low,
  output logic             sda_pull_low,
  output logic             conv_start,
  input  logic             conv_valid,
  output logic             conv_ready,
  input  logic [RES_W-1:0] conv_data,
  output logic             hs_mode
);
  import adc_i2c_pkg::*;

  localparam int         NBYTES  = RES_W / 8;
  localparam int         IDXW    = (NBYTES > 1) ? $clog2(NBYTES) : 1;
  localparam logic [7:0] RD_ADDR = {DEV_ADDR, 1'b1};

  logic [1:0] clean;
  logic       scl_f, sda_f;
  logic       scl_rise, scl_fall, start_det, stop_det;

  adc_i2c_line_filter #(.LINES(2), .FILT_LEN(FILT_LEN)) u_filter (
    .clk     (clk),
    .rst_n   (rst_n),
    .raw_i   ({scl_in, sda_in}),
    .clean_o (clean)
  );

  assign scl_f = clean[1];
  assign sda_f = clean[0];

  adc_i2c_bus_events u_events (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_f     (scl_f),
    .sda_f     (sda_f),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  rd_state_e        state;
  logic [3:0]       bit_cnt;
  logic [7:0]       shreg;
  logic [RES_W-1:0] result_q;
  logic [IDXW-1:0]  byte_idx;
  logic             master_ack;
  logic             sda_low_q, scl_low_q, start_q, hs_q;
  logic [7:0]       cur_byte, next_byte;
  logic [IDXW-1:0]  next_idx;

  assign cur_byte  = result_q[RES_W-1-8*byte_idx -: 8];
  assign next_idx  = (byte_idx == IDXW'(NBYTES - 1)) ? '0 : byte_idx + 1'b1;
  assign next_byte = result_q[RES_W-1-8*next_idx -: 8];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      bit_cnt    <= '0;
      shreg      <= '0;
      result_q   <= '0;
      byte_idx   <= '0;
      master_ack <= 1'b0;
      sda_low_q  <= 1'b0;
      scl_low_q  <= 1'b0;
      start_q    <= 1'b0;
      hs_q       <= 1'b0;
    end else begin
      start_q <= 1'b0;
      if (stop_det) begin
        state     <= ST_IDLE;
        sda_low_q <= 1'b0;
        scl_low_q <= 1'b0;
        hs_q      <= 1'b0;
      end else if (start_det) begin
        state     <= ST_ADDR;
        bit_cnt   <= '0;
        sda_low_q <= 1'b0;
      end else begin
        unique case (state)
          ST_ADDR: begin
            if (scl_rise) begin
              shreg   <= {shreg[6:0], sda_f};
              bit_cnt <= bit_cnt + 1'b1;
            end else if (scl_fall && bit_cnt == 4'd8) begin
              if (shreg == RD_ADDR) begin
                sda_low_q <= 1'b1;
                start_q   <= 1'b1;
                state     <= ST_AACK;
              end else begin
                if (shreg[7:3] == HS_CODE_PREFIX) hs_q <= 1'b1;
                state <= ST_SKIP;
              end
            end
          end
          ST_AACK: begin
            if (scl_fall) begin
              sda_low_q <= 1'b0;
              scl_low_q <= 1'b1;
              byte_idx  <= '0;
              state     <= ST_WAIT;
            end
          end
          ST_WAIT: begin
            if (conv_valid) begin
              result_q  <= conv_data;
              scl_low_q <= 1'b0;
              sda_low_q <= !conv_data[RES_W-1];
              bit_cnt   <= 4'd1;
              state     <= ST_SEND;
            end
          end
          ST_SEND: begin
            if (scl_fall) begin
              if (bit_cnt == 4'd8) begin
                sda_low_q <= 1'b0;
                state     <= ST_RACK;
              end else begin
                sda_low_q <= !cur_byte[3'd7 - bit_cnt[2:0]];
                bit_cnt   <= bit_cnt + 1'b1;
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              master_ack <= !sda_f;
            end else if (scl_fall) begin
              if (master_ack) begin
                byte_idx  <= next_idx;
                sda_low_q <= !next_byte[7];
                bit_cnt   <= 4'd1;
                state     <= ST_SEND;
              end else begin
                state <= ST_SKIP;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign scl_pull_low = scl_low_q;
  assign sda_pull_low = sda_low_q;
  assign conv_start   = start_q;
  assign conv_ready   = (state == ST_WAIT);
  assign hs_mode      = hs_q;
endmodule

// File: rtl/adc_i2c_slave_chk.sv
module adc_i2c_slave_chk
  import adc_i2c_pkg::*;
(
  input logic      clk,
  input logic      rst_n,
  input logic      scl_f,
  input logic      start_det,
  input logic      stop_det,
  input logic      conv_start,
  input logic      conv_valid,
  input logic      conv_ready,
  input logic      scl_pull_low,
  input logic      sda_pull_low,
  input logic      hs_mode,
  input rd_state_e state
);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> (!sda_pull_low && !scl_pull_low));

  assert_start_restarts_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (state == ST_ADDR));

  assert_single_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);

  assert_hold_stretch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_pull_low && !(conv_valid && conv_ready)) |=> scl_pull_low);

  assert_release_on_accept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_valid && conv_ready) |=> !scl_pull_low);

  assert_sda_moves_low_phase_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_pull_low != $past(sda_pull_low)) |-> !$past(scl_f));

  assert_stop_clears_hs_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !hs_mode);
endmodule

bind adc_i2c_slave adc_i2c_slave_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .scl_f        (scl_f),
  .start_det    (start_det),
  .stop_det     (stop_det),
  .conv_start   (conv_start),
  .conv_valid   (conv_valid),
  .conv_ready   (conv_ready),
  .scl_pull_low (scl_pull_low),
  .sda_pull_low (sda_pull_low),
  .hs_mode      (hs_mode),
  .state        (state)
);

// File: tb/test_adc_i2c_slave.sv
module test_adc_i2c_slave;
  localparam logic [6:0] ADDR = 7'h35;
  localparam int HALF = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic m_scl_low = 1'b0, m_sda_low = 1'b0;
  logic scl_pull_low, sda_pull_low, conv_start, conv_ready, hs_mode;
  logic conv_valid = 1'b0;
  logic [15:0] conv_data = '0;
  wire scl_line = !(m_scl_low || scl_pull_low);
  wire sda_line = !(m_sda_low || sda_pull_low);

  adc_i2c_slave #(.DEV_ADDR(ADDR), .RES_W(16), .FILT_LEN(4)) i_adc_i2c_slave (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_line), .sda_in(sda_line),
    .scl_pull_low(scl_pull_low), .sda_pull_low(sda_pull_low),
    .conv_start(conv_start), .conv_valid(conv_valid), .conv_ready(conv_ready),
    .conv_data(conv_data), .hs_mode(hs_mode)
  );

  int n_cmp = 0, n_bad = 0;
  int lat_cfg = 10, lat_cnt = 0, starts_seen = 0;
  logic busy = 1'b0;
  logic [15:0] conv_value = '0;
  int last_stretch = 0;
  logic glitch_now = 1'b0;
  logic done = 1'b0;

  always @(posedge clk) begin
    if (conv_valid && conv_ready) conv_valid <= 1'b0;
    if (conv_start) begin
      busy <= 1'b1;
      lat_cnt <= lat_cfg;
      starts_seen <= starts_seen + 1;
    end else if (busy) begin
      if (lat_cnt == 0) begin
        conv_valid <= 1'b1;
        conv_data <= conv_value;
        busy <= 1'b0;
      end else lat_cnt <= lat_cnt - 1;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse(output bit sample);
    int st = 0;
    m_scl_low = 1'b0;
    #1;
    while (!scl_line && st < 60000) begin
      tick(1);
      st++;
    end
    last_stretch = st;
    tick(HALF / 2);
    sample = sda_line;
    if (glitch_now) begin
      m_sda_low = !m_sda_low;
      tick(2);
      m_sda_low = !m_sda_low;
    end
    tick(HALF / 2);
    m_scl_low = 1'b1;
  endtask

  task automatic write_bit(input bit b);
    bit s;
    m_sda_low = !b;
    tick(HALF);
    pulse(s);
  endtask

  task automatic read_bit(output bit b);
    m_sda_low = 1'b0;
    tick(HALF);
    pulse(b);
  endtask

  task automatic m_start();
    m_sda_low = 1'b0;
    tick(HALF);
    m_scl_low = 1'b0;
    tick(HALF);
    m_sda_low = 1'b1;
    tick(HALF);
    m_scl_low = 1'b1;
  endtask

  task automatic m_stop();
    m_sda_low = 1'b1;
    tick(HALF);
    m_scl_low = 1'b0;
    tick(HALF);
    m_sda_low = 1'b0;
    tick(HALF);
  endtask

  task automatic write_byte(input logic [7:0] v, input int glitch_bit, output bit acked);
    bit s;
    for (int i = 7; i >= 0; i--) begin
      glitch_now = (i == glitch_bit);
      write_bit(v[i]);
    end
    glitch_now = 1'b0;
    read_bit(s);
    acked = !s;
  endtask

  task automatic read_byte(input bit give_ack, output logic [7:0] v, output int first_stretch);
    bit s;
    for (int i = 7; i >= 0; i--) begin
      read_bit(s);
      v[i] = s;
      if (i == 7) first_stretch = last_stretch;
    end
    write_bit(!give_ack);
  endtask

  task automatic t_reset();
    chk(!scl_pull_low && !sda_pull_low, "R1 lines released after reset", {scl_pull_low, sda_pull_low}, 0);
    chk(!hs_mode, "R1 hs_mode after reset", hs_mode, 0);
    chk(!conv_start, "R1 conv_start after reset", conv_start, 0);
  endtask

  task automatic t_read(input logic [15:0] val, input int lat, input bit long_wait);
    bit a;
    logic [7:0] hi, lo;
    int st, st2, s0;
    lat_cfg = lat;
    conv_value = val;
    s0 = starts_seen;
    m_start();
    write_byte({ADDR, 1'b1}, -1, a);
    chk(a, "R3 matching read address acked", a, 1);
    chk(starts_seen - s0 == 1, "R4 one conv_start per read", starts_seen - s0, 1);
    read_byte(1'b1, hi, st);
    chk(hi == val[15:8], "R6 high byte first", hi, val[15:8]);
    if (long_wait) chk(st > 500, "R5 SCL stretched during conversion", st, 500);
    else chk(st == 0, "R5 no stretch seen with ready result", st, 0);
    read_byte(1'b0, lo, st2);
    chk(lo == val[7:0], "R6 low byte second", lo, val[7:0]);
    m_stop();
    tick(20);
    chk(!sda_pull_low && !scl_pull_low && !hs_mode, "R1 idle after stop",
        {sda_pull_low, scl_pull_low, hs_mode}, 0);
  endtask

  task automatic t_bad_addr();
    bit a;
    logic [7:0] v;
    int st, s0;
    s0 = starts_seen;
    m_start();
    write_byte({ADDR ^ 7'h01, 1'b1}, -1, a);
    chk(!a, "R3 foreign address not acked", a, 0);
    read_byte(1'b1, v, st);
    chk(v == 8'hFF, "R3 SDA untouched after foreign address", v, 8'hFF);
    chk(starts_seen == s0, "R4 no conv_start for foreign address", starts_seen - s0, 0);
    m_stop();
    m_start();
    write_byte({ADDR, 1'b0}, -1, a);
    chk(!a, "R3 write direction not acked", a, 0);
    m_stop();
  endtask

  task automatic t_wrap_nack();
    bit a;
    logic [7:0] b0, b1, b2, b3;
    int st;
    lat_cfg = 30;
    conv_value = 16'hC3A7;
    m_start();
    write_byte({ADDR, 1'b1}, -1, a);
    read_byte(1'b1, b0, st);
    read_byte(1'b1, b1, st);
    read_byte(1'b0, b2, st);
    chk(b1 == 8'hA7, "R7 ACK continues to low byte", b1, 8'hA7);
    chk(b2 == 8'hC3, "R7 ACK after low byte returns to high byte", b2, 8'hC3);
    read_byte(1'b0, b3, st);
    chk(b3 == 8'hFF, "R7 SDA released after NACK", b3, 8'hFF);
    m_stop();
  endtask

  task automatic t_hs();
    bit a;
    logic [7:0] hi, lo;
    int st;
    lat_cfg = 50;
    conv_value = 16'h1234;
    m_start();
    write_byte(8'h09, -1, a);
    chk(!a, "R8 master code not acked", a, 0);
    chk(hs_mode, "R8 master code sets hs_mode", hs_mode, 1);
    m_start();
    write_byte({ADDR, 1'b1}, -1, a);
    read_byte(1'b1, hi, st);
    read_byte(1'b0, lo, st);
    chk({hi, lo} == 16'h1234, "R8 read in high-speed mode", {hi, lo}, 16'h1234);
    chk(hs_mode, "R8 hs_mode kept across repeated START", hs_mode, 1);
    m_stop();
    tick(20);
    chk(!hs_mode, "R8 STOP clears hs_mode", hs_mode, 0);
  endtask

  task automatic t_abort();
    bit a;
    logic [7:0] hi, lo;
    int st;
    lat_cfg = 20;
    conv_value = 16'h5AC3;
    m_start();
    write_bit(1'b0);
    write_bit(1'b1);
    write_bit(1'b1);
    write_bit(1'b0);
    m_start();
    write_byte({ADDR, 1'b1}, -1, a);
    chk(a, "R2 repeated START mid-byte restarts address", a, 1);
    read_byte(1'b1, hi, st);
    read_byte(1'b0, lo, st);
    chk({hi, lo} == 16'h5AC3, "R2 read after aborted byte", {hi, lo}, 16'h5AC3);
    m_stop();
  endtask

  task automatic t_glitch();
    bit a;
    logic [7:0] hi, lo;
    int st;
    lat_cfg = 20;
    conv_value = 16'h0F0F;
    m_start();
    write_byte({ADDR, 1'b1}, 1, a);
    chk(a, "R9 short SDA spike during SCL high ignored", a, 1);
    read_byte(1'b1, hi, st);
    read_byte(1'b0, lo, st);
    chk({hi, lo} == 16'h0F0F, "R9 data intact after spike", {hi, lo}, 16'h0F0F);
    m_stop();
  endtask

  initial begin
    tick(10);
    rst_n = 1'b1;
    tick(10);
    t_reset();
    t_read(16'hA55A, 1000, 1'b1);
    t_read(16'h8001, 2, 1'b0);
    t_bad_addr();
    t_wrap_nack();
    t_hs();
    t_abort();
    t_glitch();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule